// File: doc/BRIEF.md
# Card-Under-Test Circuit Masking Sequencer

This block steers the probe pins of a board-level functional tester so that only one circuit on the card under test is exercised at a time. A synchronous start captures a two-bit card-group code and a binary card identifier. The sequencer then walks an IC index across the card in fixed 8-pin windows and produces a per-pin enable vector. That vector is the product of the pin-usage mask, the window of the selected IC and, for cards whose ICs hold several circuits, an intra-IC lane mask read from a small internal lookup memory.

For multi-circuit cards the scan is nested. The lane mask is held while every IC is visited. A circuit-advance pulse issued at the last IC then moves the memory address by one, and the IC index returns to the first IC. Single-IC cards bypass windowing altogether. Cards with six or five single-circuit ICs step only the IC window. A done flag marks the end of the scan, and every pin stays dark until the next start.

Top module: `cms_seq`

## Requirements
- R1: After reset, `done` is 0, `ic_sel` is 0, `mem_addr` is 0, and `pin_en` and `pin_drv` are all zero until the first `start`.
- R2: A cycle with `start` high loads the block from that cycle's inputs, and this wins over any pulse in the same cycle. The block leaves `done`, sets `ic_sel` to 0 and sets `mem_addr` to `card_id * 4` (the identifier shifted left by two). It captures `card_grp`, which is encoded as 00 single circuit, 01 six ICs, 10 five ICs and 11 multi-circuit.
- R3: For group 00, `pin_en` equals `io_used` with no windowing. The first accepted `ic_adv` sets `done`.
- R4: For group 01, `pin_en` is `io_used` restricted to pins `8*ic_sel` to `8*ic_sel+7`. Each accepted `ic_adv` increments `ic_sel`, and an `ic_adv` at IC 5 sets `done`.
- R5: Group 10 is stepped exactly like group 01 with five ICs, so an `ic_adv` at IC 4 sets `done`.
- R6: For group 11, the number of circuits per IC is n = 2 + (`card_id` mod 3). Circuit k (k = `mem_addr` - start address) owns the window offsets p (0..7) with p mod n = k. `pin_en` is `io_used` restricted to the selected window and to those offsets.
- R7: For group 11, `ic_adv` steps `ic_sel` up to IC 5 and is ignored there. A `circ_adv` at IC 5 increments `mem_addr` by exactly one and returns `ic_sel` to 0. A `circ_adv` at any other IC is ignored.
- R8: For group 11, a `circ_adv` at IC 5 on circuit n-1 sets `done` and leaves `mem_addr` unchanged.
- R9: `pin_drv` equals `pin_en & io_dir`. A 1 in `io_dir` makes an enabled pin a stimulus output, and a 0 makes it a response input.
- R10: While `enable` is low, `ic_adv` and `circ_adv` have no effect on `ic_sel`, `mem_addr`, `done` or `pin_en`.
- R11: Once `done` is set, it stays set until `start`. All pins are disabled, and pulses change neither `ic_sel` nor `mem_addr`.
- R12: In groups 00, 01 and 10, `circ_adv` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| start | input | 1 | Synchronous load of group and identifier |
| enable | input | 1 | Allows advance pulses to act |
| card_grp | input | 2 | Card group code (00/01/10/11) |
| card_id | input | 4 | Binary card identifier |
| io_used | input | 48 | Pins used by the card under test |
| io_dir | input | 48 | Per-pin direction, 1 = stimulus output |
| ic_adv | input | 1 | IC-advance pulse |
| circ_adv | input | 1 | Circuit-advance pulse |
| ic_sel | output | 3 | Index of the IC under test |
| mem_addr | output | 6 | Lane-mask memory address |
| pin_en | output | 48 | Per-pin enable |
| pin_drv | output | 48 | Per-pin drive enable |
| done | output | 1 | Scan complete |

## Verification
The assertions assume that `card_grp` and `card_id` matter only in a `start` cycle. They also assume that `ic_sel` and `mem_addr` can move only by a single step or by a reload to the first IC, so no input pattern may jump them arbitrarily. The stimulus changes every input away from the active edge and holds the group and identifier stable around each start. It exercises the ignored-pulse cases (enable low, after done, out-of-turn circuit pulses, and both pulses together) only through the normal pulse inputs. Each phase uses several `io_used` and `io_dir` patterns, so that both the windowing and the lane masking show up in the compared pin vectors.

// File: rtl/cms_pkg.sv
package cms_pkg;

   typedef enum logic [1:0] {
      GRP_SINGLE = 2'b00,
      GRP_SIX    = 2'b01,
      GRP_FIVE   = 2'b10,
      GRP_MULTI  = 2'b11
   } card_grp_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_DONE = 2'b10
   } seq_state_e;

   // circuits per IC for a multi-circuit card, from its identifier
   function automatic int unsigned circ_count(int unsigned id);
      return 2 + (id % 3);
   endfunction

   // largest value circ_count can return
   localparam int unsigned CIRC_MAX = 4;

endpackage

// File: rtl/cms_start_decode.sv
module cms_start_decode #(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned SLOT_W = 2
) (
   input  logic [ID_W-1:0]        card_id,
   output logic [ID_W+SLOT_W-1:0] start_addr,
   output logic [SLOT_W:0]        n_circ
);

   assign start_addr = {card_id, {SLOT_W{1'b0}}};

   always_comb begin
      n_circ = (SLOT_W+1)'(cms_pkg::circ_count(int'(card_id)));
   end

endmodule

// File: rtl/cms_mask_rom.sv
module cms_mask_rom #(
   parameter int unsigned ID_W   = 4,
   parameter int unsigned SLOT_W = 2,
   parameter int unsigned LANES  = 8,
   localparam int unsigned ADDR_W = ID_W + SLOT_W,
   localparam int unsigned DEPTH  = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [LANES-1:0]  lane_mask
);

   logic [DEPTH*LANES-1:0] rom_flat;

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      localparam int unsigned N = cms_pkg::circ_count(a >> SLOT_W);
      localparam int unsigned K = a % (1 << SLOT_W);
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign rom_flat[a*LANES + l] = (K < N) && ((l % N) == K);
      end
   end

   assign lane_mask = rom_flat[addr*LANES +: LANES];

endmodule

// File: rtl/cms_pin_gate.sv
module cms_pin_gate #(
   parameter int unsigned PINS_PER_IC = 8,
   parameter int unsigned MAX_ICS     = 6,
   parameter int unsigned IC_W        = 3,
   localparam int unsigned NUM_PINS   = PINS_PER_IC * MAX_ICS
) (
   input  logic                   active,
   input  logic                   win_on,
   input  logic                   lane_on,
   input  logic [IC_W-1:0]        ic_sel,
   input  logic [PINS_PER_IC-1:0] lane_mask,
   input  logic [NUM_PINS-1:0]    io_used,
   input  logic [NUM_PINS-1:0]    io_dir,
   output logic [NUM_PINS-1:0]    pin_en,
   output logic [NUM_PINS-1:0]    pin_drv
);

   logic [PINS_PER_IC-1:0] lanes;
   assign lanes = lane_on ? lane_mask : {PINS_PER_IC{1'b1}};

   for (genvar i = 0; i < MAX_ICS; i++) begin : g_win
      logic hit;
      assign hit = active && (!win_on || (ic_sel == IC_W'(i)));
      assign pin_en[i*PINS_PER_IC +: PINS_PER_IC] =
         hit ? (io_used[i*PINS_PER_IC +: PINS_PER_IC] & lanes) : '0;
   end

   assign pin_drv = pin_en & io_dir;

endmodule

// File: rtl/cms_seq.sv
module cms_seq #(
   parameter int unsigned PINS_PER_IC = 8,
   parameter int unsigned MAX_ICS     = 6,
   parameter int unsigned ID_W        = 4,
   parameter int unsigned SLOT_W      = 2,
   parameter int unsigned ICS_GRP_B   = 6,
   parameter int unsigned ICS_GRP_C   = 5,
   parameter int unsigned ICS_GRP_D   = 6,
   localparam int unsigned NUM_PINS   = PINS_PER_IC * MAX_ICS,
   localparam int unsigned IC_W       = (MAX_ICS > 1) ? $clog2(MAX_ICS) : 1,
   localparam int unsigned ADDR_W     = ID_W + SLOT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                enable,
   input  logic [1:0]          card_grp,
   input  logic [ID_W-1:0]     card_id,
   input  logic [NUM_PINS-1:0] io_used,
   input  logic [NUM_PINS-1:0] io_dir,
   input  logic                ic_adv,
   input  logic                circ_adv,
   output logic [IC_W-1:0]     ic_sel,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [NUM_PINS-1:0] pin_en,
   output logic [NUM_PINS-1:0] pin_drv,
   output logic                done
);
   import cms_pkg::*;

   // elaboration-time parameter checks
   if (ICS_GRP_B > MAX_ICS || ICS_GRP_C > MAX_ICS || ICS_GRP_D > MAX_ICS) begin : g_bad_ics
      $error("cms_seq: group IC count exceeds MAX_ICS");
   end
   if (ICS_GRP_B == 0 || ICS_GRP_C == 0 || ICS_GRP_D == 0) begin : g_zero_ics
      $error("cms_seq: group IC count must be nonzero");
   end
   if (CIRC_MAX > (1 << SLOT_W) || CIRC_MAX > PINS_PER_IC) begin : g_bad_slot
      $error("cms_seq: SLOT_W or PINS_PER_IC too small for circuit count");
   end

   function automatic int unsigned ics_for(card_grp_e g);
      case (g)
         GRP_SINGLE: return 1;
         GRP_SIX:    return ICS_GRP_B;
         GRP_FIVE:   return ICS_GRP_C;
         default:    return ICS_GRP_D;
      endcase
   endfunction

   seq_state_e          state_q;
   card_grp_e           grp_q;
   logic [IC_W-1:0]     ic_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [SLOT_W-1:0]   circ_q;
   logic [SLOT_W:0]     ncirc_q;

   logic [ADDR_W-1:0]   dec_start;
   logic [SLOT_W:0]     dec_ncirc;
   logic                last_ic;
   logic                last_circ;
   logic                accept;
   logic [PINS_PER_IC-1:0] lane_word;

   cms_start_decode #(.ID_W(ID_W), .SLOT_W(SLOT_W)) u_dec (
      .card_id    (card_id),
      .start_addr (dec_start),
      .n_circ     (dec_ncirc)
   );

   assign last_ic   = (ic_q == IC_W'(ics_for(grp_q) - 1));
   assign last_circ = ({1'b0, circ_q} == (ncirc_q - 1'b1));
   assign accept    = enable && (state_q == ST_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         grp_q   <= GRP_SINGLE;
         ic_q    <= '0;
         addr_q  <= '0;
         circ_q  <= '0;
         ncirc_q <= '0;
      end else if (start) begin
         state_q <= ST_RUN;
         grp_q   <= card_grp_e'(card_grp);
         ic_q    <= '0;
         addr_q  <= dec_start;
         circ_q  <= '0;
         ncirc_q <= dec_ncirc;
      end else if (accept) begin
         if (ic_adv && !last_ic) begin
            ic_q <= ic_q + 1'b1;
         end else if (ic_adv && (grp_q != GRP_MULTI)) begin
            state_q <= ST_DONE;
         end else if (circ_adv && last_ic && (grp_q == GRP_MULTI)) begin
            if (last_circ) begin
               state_q <= ST_DONE;
            end else begin
               addr_q <= addr_q + 1'b1;
               circ_q <= circ_q + 1'b1;
               ic_q   <= '0;
            end
         end
      end
   end

   cms_mask_rom #(.ID_W(ID_W), .SLOT_W(SLOT_W), .LANES(PINS_PER_IC)) u_rom (
      .addr      (addr_q),
      .lane_mask (lane_word)
   );

   cms_pin_gate #(.PINS_PER_IC(PINS_PER_IC), .MAX_ICS(MAX_ICS), .IC_W(IC_W)) u_gate (
      .active    (state_q == ST_RUN),
      .win_on    (grp_q != GRP_SINGLE),
      .lane_on   (grp_q == GRP_MULTI),
      .ic_sel    (ic_q),
      .lane_mask (lane_word),
      .io_used   (io_used),
      .io_dir    (io_dir),
      .pin_en    (pin_en),
      .pin_drv   (pin_drv)
   );

   assign ic_sel   = ic_q;
   assign mem_addr = addr_q;
   assign done     = (state_q == ST_DONE);

endmodule

// File: rtl/cms_seq_chk.sv
module cms_seq_chk #(
   parameter int unsigned NUM_PINS    = 48,
   parameter int unsigned PINS_PER_IC = 8,
   parameter int unsigned IC_W        = 3,
   parameter int unsigned ADDR_W      = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                enable,
   input logic [1:0]          grp_q,
   input logic [NUM_PINS-1:0] io_used,
   input logic [IC_W-1:0]     ic_sel,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [NUM_PINS-1:0] pin_en,
   input logic [NUM_PINS-1:0] pin_drv,
   input logic                done
);

   logic [NUM_PINS-1:0] win;
   always_comb begin
      win = {{(NUM_PINS-PINS_PER_IC){1'b0}}, {PINS_PER_IC{1'b1}}} << (ic_sel * PINS_PER_IC);
   end

   a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (ic_sel == '0) && !done);

   a_r10_enable_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !enable) |=> ($stable(ic_sel) && $stable(mem_addr) && $stable(done)));

   a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(ic_sel) && $stable(mem_addr)));

   a_r11_done_dark: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pin_en == '0));

   a_r9_drive_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_drv & ~pin_en) == '0);

   a_r3_used_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en & ~io_used) == '0);

   a_r4_one_window: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q != 2'b00) |-> ((pin_en & ~win) == '0));

   a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (mem_addr == $past(mem_addr)) || (mem_addr == ($past(mem_addr) + 1'b1)));

   a_r7_ic_step: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (ic_sel == $past(ic_sel)) || (ic_sel == ($past(ic_sel) + 1'b1)) || (ic_sel == '0));

endmodule

bind cms_seq cms_seq_chk #(
   .NUM_PINS(NUM_PINS), .PINS_PER_IC(PINS_PER_IC), .IC_W(IC_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .enable(enable), .grp_q(grp_q),
   .io_used(io_used), .ic_sel(ic_sel), .mem_addr(mem_addr), .pin_en(pin_en),
   .pin_drv(pin_drv), .done(done)
);

// File: tb/cms_seq_tb_top.sv
`timescale 1ns/1ps
module cms_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  card_grp = 2'b00;
   logic [3:0]  card_id = 4'd0;
   logic [47:0] io_used = '0;
   logic [47:0] io_dir = '0;
   logic        ic_adv = 1'b0;
   logic        circ_adv = 1'b0;
   logic [2:0]  ic_sel;
   logic [5:0]  mem_addr;
   logic [47:0] pin_en;
   logic [47:0] pin_drv;
   logic        done;

   int    n_checks = 0;
   int    n_errors = 0;
   string cur_req = "R1";

   // reference model state
   int m_state = 0;   // 0 idle, 1 running, 2 done
   int m_grp = 0, m_ic = 0, m_addr = 0, m_circ = 0, m_n = 2;

   always #2.5 clk = ~clk;

   cms_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .enable(enable),
      .card_grp(card_grp), .card_id(card_id), .io_used(io_used), .io_dir(io_dir),
      .ic_adv(ic_adv), .circ_adv(circ_adv), .ic_sel(ic_sel), .mem_addr(mem_addr),
      .pin_en(pin_en), .pin_drv(pin_drv), .done(done)
   );

   function automatic int ics_of(int g);
      case (g)
         0: return 1;
         1: return 6;
         2: return 5;
         default: return 6;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_grp = 0; m_ic = 0; m_addr = 0; m_circ = 0; m_n = 2;
      end else if (start) begin
         m_state = 1; m_grp = int'(card_grp); m_ic = 0; m_circ = 0;
         m_addr = int'(card_id) * 4; m_n = 2 + int'(card_id) % 3;
      end else if (enable && m_state == 1) begin
         if (ic_adv && m_ic < ics_of(m_grp) - 1) m_ic = m_ic + 1;
         else if (ic_adv && m_grp != 3) m_state = 2;
         else if (circ_adv && m_grp == 3 && m_ic == ics_of(m_grp) - 1) begin
            if (m_circ == m_n - 1) m_state = 2;
            else begin m_circ = m_circ + 1; m_addr = m_addr + 1; m_ic = 0; end
         end
      end
   end

   function automatic logic [47:0] exp_pins();
      logic [47:0] v = '0;
      for (int p = 0; p < 48; p++) begin
         bit ok = (m_state == 1) && io_used[p];
         if (m_grp != 0 && (p / 8) != m_ic) ok = 0;
         if (m_grp == 3 && ((p % 8) % m_n) != m_circ) ok = 0;
         v[p] = ok;
      end
      return v;
   endfunction

   task automatic chk(string what, logic [47:0] act, logic [47:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      logic [47:0] e = exp_pins();
      chk("ic_sel", 48'(ic_sel), 48'(m_ic));
      chk("mem_addr", 48'(mem_addr), 48'(m_addr));
      chk("done", 48'(done), 48'(m_state == 2));
      chk("pin_en", pin_en, e);
      chk("pin_drv", pin_drv, e & io_dir);
   endtask

   // one cycle: compare at mid-period, then drive the next inputs
   task automatic cyc(logic st, logic en, logic ia, logic ca);
      @(negedge clk);
      #0.5;
      if (rst_n) compare();
      start = st; enable = en; ic_adv = ia; circ_adv = ca;
   endtask

   task automatic begin_card(int g, int id);
      card_grp = 2'(g); card_id = 4'(id);
      cyc(1, 1, 0, 0);
      cyc(0, 1, 0, 0);
   endtask

   initial begin
      #(5.0 * 100000);
      n_errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      io_used = 48'hF0F0_A5A5_FFFF; io_dir = 48'h0F0F_3C3C_00FF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, pulses before any start do nothing
      cur_req = "R1";
      cyc(0, 1, 1, 0); cyc(0, 1, 0, 1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
      n_checks++;
      if (done !== 1'b0 || pin_en !== '0) begin
         n_errors++; $display("FAIL R1 idle act=%b/%h exp=0/0", done, pin_en);
      end

      // R3 single-circuit card, no windowing
      cur_req = "R3";
      io_used = 48'h1234_5678_9ABC; io_dir = 48'hFFFF_0000_FFFF;
      begin_card(0, 7);
      cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0);

      // R12 circuit pulses ignored in six-IC group; R4 stepping
      cur_req = "R12";
      io_used = '1; io_dir = 48'hAAAA_5555_F00F;
      begin_card(1, 2);
      cyc(0, 1, 0, 1); cyc(0, 1, 0, 1); cyc(0, 1, 0, 0);
      cur_req = "R4";
      for (int i = 0; i < 6; i++) begin cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); end
      cyc(0, 1, 0, 0);

      // R11 after done
      cur_req = "R11";
      for (int i = 0; i < 4; i++) cyc(0, 1, i[0], ~i[0]);
      cyc(0, 1, 0, 0);

      // R5 five-IC group, back-to-back pulses
      cur_req = "R5";
      io_used = 48'hDEAD_BEEF_CAFE; io_dir = 48'h0123_4567_89AB;
      begin_card(2, 9);
      for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
      cyc(0, 1, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0);

      // R6/R7/R8 multi-circuit card, id 5 -> four circuits
      cur_req = "R7";
      io_used = '1; io_dir = 48'hFF00_FF00_FF00;
      begin_card(3, 5);
      cyc(0, 1, 0, 1); cyc(0, 1, 0, 0);          // early circuit pulse ignored
      cur_req = "R6";
      for (int c = 0; c < 4; c++) begin
         for (int i = 0; i < 6; i++) begin cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); end
         cyc(0, 1, 1, 0);                          // ic pulse at last IC ignored
         cur_req = (c == 3) ? "R8" : "R7";
         cyc(0, 1, 1, 1); cyc(0, 1, 0, 0);        // circuit step (or finish)
      end
      cyc(0, 1, 0, 0);
      n_checks++;
      if (done !== 1'b1 || mem_addr !== 6'd23) begin
         n_errors++; $display("FAIL R8 end act=%b/%0d exp=1/23", done, mem_addr);
      end

      // R10 enable low, id 13 -> three circuits
      cur_req = "R10";
      io_used = 48'h5A5A_C3C3_7E7E; io_dir = 48'hFFFF_FFFF_0000;
      begin_card(3, 13);
      cyc(0, 1, 1, 0); cyc(0, 0, 1, 0); cyc(0, 0, 0, 1); cyc(0, 0, 1, 1);
      cur_req = "R6";
      for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
      cyc(0, 0, 0, 1); cyc(0, 1, 0, 1); cyc(0, 1, 0, 0);

      // R2 restart mid-scan with pulses in the start cycle; id 3 -> two circuits
      cur_req = "R2";
      card_grp = 2'd3; card_id = 4'd3;
      cyc(1, 1, 1, 1); cyc(0, 1, 0, 0);
      cur_req = "R9";
      io_dir = 48'h8421_8421_8421;
      for (int c = 0; c < 2; c++) begin
         for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
         cyc(0, 1, 0, 1); io_dir = ~io_dir; cyc(0, 1, 0, 0);
      end
      cur_req = "R2";
      card_grp = 2'd1; card_id = 4'd15;
      cyc(1, 0, 0, 0); cyc(0, 1, 1, 0); cyc(0, 1, 0, 0); cyc(0, 1, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule